// File: doc/BRIEF.md
# Countdown Seconds Alarm

This block is a relative alarm. Software loads a number of seconds and enables counting, and the block then counts down by one on every one-second tick. When the count steps from one to zero, the block raises a sticky pending flag and stops. The flag drives a level interrupt and a wakeup request, and each has its own enable. Software clears the flag by writing one to it. Calendar-time comparison and the generation of the tick itself belong to other blocks.

Software reaches the block through a single-cycle write port and a combinational read port, each addressed by word. A control FSM holds the counting state. In `ST_IDLE` counting is switched off and ticks are ignored. In `ST_COUNT` counting is on and the value is nonzero, so each tick decrements it. In `ST_ZERO` counting is on but the value is zero, so the block waits for a new nonzero load.

The FSM recomputes its state on every clock from the next enable and the next count. It takes these transitions:
- idle-to-count: enable set with a nonzero value.
- idle-to-zero: enable set with a zero value.
- count-to-zero: either the final tick (the expiry) or a zero load.
- zero-to-count: a nonzero load.
- any-to-idle: enable cleared.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset every readable register reads 0, and `irq` and `wake_req` are low.
- R2: A write to address 0 stores the value as the load value (read back at address 0). From the next cycle the same value is also the current count (read at address 1).
- R3: While the run bit (address 2, bit 0) is 1 and the current count is nonzero, each cycle with `tick` high decrements the count by exactly one. While the run bit is 0, ticks leave the count unchanged.
- R4: A tick that takes the count from 1 to 0 sets the pending flag (address 4, bit 0) in the next cycle. Later ticks leave the count at 0 and do not set the flag again.
- R5: A load write wins over a tick in the same cycle. Loading 0 never sets the pending flag. Loading 0 and then a nonzero value restarts the countdown from the new value.
- R6: Writing 1 to address 4, bit 0 clears the pending flag, and writing 0 there has no effect. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when the pending flag and the interrupt enable (address 3, bit 0) are both 1.
- R8: `wake_req` is high exactly when the pending flag and the wakeup enable (address 5, bit 0) are both 1.
- R9: Writes to address 1 are ignored. Reads of addresses 6 and 7 return 0.
- R10: Addresses 2, 3 and 5 read back their bit 0 as last written, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt |
| wake_req | output | 1 | Wakeup request |

## Verification
On every cycle, the embedded assertions check that a counted tick lowers the count by exactly one and that an idle or zero count stays put. They also check that an expiry always leaves the flag set and that a clear without an expiry drops it. Finally, they check that neither output can be high while the flag is clear. Only the bench scenarios show the ordering cases: a load colliding with a tick, a clear colliding with an expiry, a restart through a zero load, an ignored write to the read-only count, and the exact cycle in which each readback changes. A behavioural model in the bench checks all of these on every clock.

// File: rtl/cd_alarm_pkg.sv
package cd_alarm_pkg;
    localparam int ADR_LOAD = 0;
    localparam int ADR_CUR  = 1;
    localparam int ADR_RUN  = 2;
    localparam int ADR_IEN  = 3;
    localparam int ADR_STAT = 4;
    localparam int ADR_WAKE = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ZERO  = 2'd2
    } cd_state_e;
endpackage

// File: rtl/cd_alarm_regs.sv
module cd_alarm_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] cur_cnt,
    input  logic              run_on,
    input  logic              pend,
    output logic [DATA_W-1:0] rd_data,
    output logic              ld_wr,
    output logic              run_wr,
    output logic              clr_wr,
    output logic              ien_q,
    output logic              wake_en_q
);
    import cd_alarm_pkg::*;

    logic [DATA_W-1:0] load_q;

    always_comb begin
        ld_wr  = wr_en && (wr_addr == ADDR_W'(ADR_LOAD));
        run_wr = wr_en && (wr_addr == ADDR_W'(ADR_RUN));
        clr_wr = wr_en && (wr_addr == ADDR_W'(ADR_STAT)) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q    <= '0;
            ien_q     <= 1'b0;
            wake_en_q <= 1'b0;
        end else begin
            if (ld_wr)
                load_q <= wr_data;
            if (wr_en && (wr_addr == ADDR_W'(ADR_IEN)))
                ien_q <= wr_data[0];
            if (wr_en && (wr_addr == ADDR_W'(ADR_WAKE)))
                wake_en_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_LOAD))
            rd_data = load_q;
        else if (rd_addr == ADDR_W'(ADR_CUR))
            rd_data = cur_cnt;
        else if (rd_addr == ADDR_W'(ADR_RUN))
            rd_data[0] = run_on;
        else if (rd_addr == ADDR_W'(ADR_IEN))
            rd_data[0] = ien_q;
        else if (rd_addr == ADDR_W'(ADR_STAT))
            rd_data[0] = pend;
        else if (rd_addr == ADDR_W'(ADR_WAKE))
            rd_data[0] = wake_en_q;
    end
endmodule

// File: rtl/cd_alarm_count.sv
module cd_alarm_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_wr,
    input  logic              run_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cnt_q,
    output logic              run_on,
    output logic              expire
);
    import cd_alarm_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    cd_state_e         state_q, state_d;
    logic [DATA_W-1:0] cnt_d;
    logic              en_d;
    logic              step;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        step  = 1'b0;
        cnt_d = cnt_q;
        unique case (state_q)
            ST_IDLE:  step = 1'b0;
            ST_COUNT: step = tick && !ld_wr;
            ST_ZERO:  step = 1'b0;
            default:  step = 1'b0;
        endcase
        if (ld_wr)
            cnt_d = wr_data;
        else if (step)
            cnt_d = cnt_q - ONE;
        en_d = run_wr ? wr_data[0] : (state_q != ST_IDLE);
        if (!en_d)
            state_d = ST_IDLE;
        else if (cnt_d != '0)
            state_d = ST_COUNT;
        else
            state_d = ST_ZERO;
    end

    always_comb begin
        run_on = (state_q != ST_IDLE);
        expire = step && (cnt_q == ONE);
    end

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && !ld_wr) |=> (cnt_q == $past(cnt_q) - ONE));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !ld_wr) |=> $stable(cnt_q));
    // R4
    zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !ld_wr) |=> (cnt_q == '0));
endmodule

// File: rtl/cd_alarm_status.sv
module cd_alarm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_wr,
    input  logic ien_q,
    input  logic wake_en_q,
    output logic pend,
    output logic irq,
    output logic wake_req
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (expire)
            pend <= 1'b1;
        else if (clr_wr)
            pend <= 1'b0;
    end

    always_comb begin
        irq      = pend && ien_q;
        wake_req = pend && wake_en_q;
    end

    // R4
    expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr_wr && !expire) |=> !pend);
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !irq);
    // R8
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> !wake_req);
endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              wake_req
);
    logic [DATA_W-1:0] cnt_q;
    logic              run_on, expire, pend;
    logic              ld_wr, run_wr, clr_wr, ien_q, wake_en_q;

    cd_alarm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cur_cnt(cnt_q),
        .run_on(run_on), .pend(pend), .rd_data(rd_data), .ld_wr(ld_wr),
        .run_wr(run_wr), .clr_wr(clr_wr), .ien_q(ien_q), .wake_en_q(wake_en_q)
    );

    cd_alarm_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_wr(ld_wr),
        .run_wr(run_wr), .wr_data(wr_data), .cnt_q(cnt_q),
        .run_on(run_on), .expire(expire)
    );

    cd_alarm_status u_status (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_wr(clr_wr),
        .ien_q(ien_q), .wake_en_q(wake_en_q), .pend(pend),
        .irq(irq), .wake_req(wake_req)
    );
endmodule

// File: tb/sec_countdown_alarm_test.sv
`timescale 1ns/1ps
module sec_countdown_alarm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, wake_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [31:0] m_load = '0, m_cur = '0;
    bit m_en = 0, m_ien = 0, m_wk = 0, m_pend = 0;

    always #5 clk = ~clk;

    sec_countdown_alarm uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .wake_req(wake_req)
    );

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cur;
            3'd2: return {31'b0, m_en};
            3'd3: return {31'b0, m_ien};
            3'd4: return {31'b0, m_pend};
            3'd5: return {31'b0, m_wk};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R10";
            3'd3: return "R10";
            3'd4: return "R6";
            3'd5: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, compare registered state, advance model
    task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d,
                        input bit t, input logic [2:0] ra);
        bit ld, exp_ev, clr;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; tick = t; rd_addr = ra;
        #1;
        cmp(rd_tag(ra), rd_data, exp_rd(ra));
        cmp("R7", {31'b0, irq}, {31'b0, m_pend && m_ien});
        cmp("R8", {31'b0, wake_req}, {31'b0, m_pend && m_wk});
        ld     = w && a == 3'd0;
        exp_ev = m_en && t && !ld && m_cur == 32'd1;
        clr    = w && a == 3'd4 && d[0];
        if (ld) begin
            m_load = d; m_cur = d;
        end else if (m_en && t && m_cur != 0) begin
            m_cur = m_cur - 1;
        end
        if (w && a == 3'd2) m_en  = d[0];
        if (w && a == 3'd3) m_ien = d[0];
        if (w && a == 3'd5) m_wk  = d[0];
        if (exp_ev) m_pend = 1;
        else if (clr) m_pend = 0;
    endtask

    task automatic idle(input bit t, input logic [2:0] ra);
        step(0, 3'd0, 32'd0, t, ra);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state on every address, R9 unmapped reads
        for (int i = 0; i < 8; i++) idle(0, 3'(i));
        // R2 load 5, then read load and current
        step(1, 3'd0, 32'd5, 0, 3'd0);
        idle(0, 3'd0);
        idle(0, 3'd1);
        // R3 ticks ignored while run bit clear
        for (int i = 0; i < 3; i++) idle(1, 3'd1);
        // R7 R8 R10 enable interrupt, wakeup, run
        step(1, 3'd3, 32'd1, 0, 3'd3);
        step(1, 3'd5, 32'hFFFF_FFFF, 0, 3'd5);
        step(1, 3'd2, 32'd1, 0, 3'd2);
        // R3 countdown with gaps, R4 expiry
        for (int i = 0; i < 5; i++) begin
            idle(1, 3'd1);
            idle(0, 3'd4);
        end
        // R4 further ticks hold zero, no re-set after clear
        step(1, 3'd4, 32'd0, 0, 3'd4);   // R6 write 0 no effect
        step(1, 3'd4, 32'd1, 0, 3'd4);   // R6 clear
        for (int i = 0; i < 3; i++) idle(1, 3'd4);
        idle(0, 3'd1);
        // R5 load 0 sets nothing, then nonzero restarts
        step(1, 3'd0, 32'd0, 1, 3'd4);
        idle(1, 3'd4);
        step(1, 3'd0, 32'd3, 0, 3'd1);
        idle(1, 3'd1);
        // R5 load collides with tick: load wins
        step(1, 3'd0, 32'd2, 1, 3'd1);
        idle(0, 3'd1);
        idle(1, 3'd1);
        // R6 expiry and clear in the same cycle: set wins
        step(1, 3'd4, 32'd1, 1, 3'd4);
        idle(0, 3'd4);
        // R7 interrupt disabled while pending, R8 wakeup disabled
        step(1, 3'd3, 32'd0, 0, 3'd3);
        idle(0, 3'd4);
        step(1, 3'd5, 32'd0, 0, 3'd5);
        idle(0, 3'd4);
        step(1, 3'd3, 32'd1, 0, 3'd3);
        // R9 write to current count ignored
        step(1, 3'd1, 32'd77, 0, 3'd1);
        idle(0, 3'd1);
        idle(0, 3'd6);
        idle(0, 3'd7);
        // R3 full-width value decrements
        step(1, 3'd0, 32'hFFFF_FFFF, 0, 3'd0);
        idle(1, 3'd1);
        idle(0, 3'd1);
        // R3 disable mid-count freezes value
        step(1, 3'd2, 32'd0, 0, 3'd2);
        idle(1, 3'd1);
        idle(1, 3'd1);
        step(1, 3'd4, 32'd1, 0, 3'd4);
        idle(0, 3'd4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule